// File: doc/BRIEF.md
# Shared-Period Eight-Channel PWM Timer

This block produces eight edge-aligned pulse-width-modulated outputs from one free-running 16-bit up-counter. Every channel shares that counter, so all eight outputs have the same period. Each channel sets its own duty cycle with a compare value. The counter advances on ticks taken from one of three sources: the system clock, a fixed-rate enable pulse, or an external clock input sampled in the system domain. A power-of-two prescaler sits between the selected source and the counter.

Software programs the block through a 32-bit register port with a single write strobe and a read path that responds at once to the address. The start value, the end value and the compare values can change while the timer runs. Changes to the end value and to the compare values are held until the counter wraps, so a period is never cut short. Each output can be forced to a programmable idle level, and its sense can be inverted.

Top module: `shared_pwm_timer`

## Requirements
- R1: Register offsets: control at 0x00 (prescale code in bits 2:0, source code in bits 4:3), counter at 0x04, end value at 0x08, channel n mode at 0x0C+8n, channel n compare at 0x10+8n, start value at 0x4C, idle levels at 0x5C, mask at 0x60, invert at 0x70. Every register except the counter reads back the last value written, within its width: 32 bits for control, 16 bits for the end, start and compare values, 8 bits for the others.
- R2: Source code 0 stops the counter. Code 1 ticks on every system clock, code 2 on each cycle that `fix_tick` is high, and code 3 on the external clock.
- R3: With prescale code P, the counter advances once every 2^P ticks of the selected source.
- R4: On an advancing tick, the counter loads the start value when it is at or above the end value. Otherwise it increments. The period is therefore END+1-START counts.
- R5: A channel is in PWM mode when bits 5 and 3 of its mode register are both set. In that mode its output is active while the counter is below the compare value. A channel not in PWM mode is inactive (0).
- R6: With start value 0, a compare value of 0 gives a constant inactive output, and a compare value above the end value gives a constant active output.
- R7: Writes to the end value and to the compare values take effect at the next counter wrap, or at once while the source code is 0.
- R8: When mask bit n is set, channel n drives bit n of the idle-level register instead of its PWM level. All mask bits are 1 after reset, so all outputs are 0 after reset.
- R9: Invert bit n flips output n, both the PWM level and the masked idle level.
- R10: The counter register returns the live count. Writes to it are ignored.
- R11: The external clock passes through a two-flop synchroniser, and each of its rising edges gives one tick.
- R12: Outputs are registered: `pwm_out` reflects the counter value of the previous system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fix_tick | input | 1 | Fixed-rate tick enable, system clock domain |
| ext_clk | input | 1 | External counter clock, asynchronous |
| bus_wr | input | 1 | Write strobe, registered at the clock edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 8 | Channel outputs |

## Verification
The hardest case to reach is a compare-value write that lands in the middle of a running period: its effect must stay hidden until the counter wraps. The bench polls the live counter through the register port until it reads a known count. It then raises the write strobe in that same cycle, so the write lands at a known counter position. The output two cycles later is compared against the level the old compare value gives. Duty checks count high cycles over a window of exactly one period, which makes them independent of where the window starts.

// File: rtl/pwm_timer_pkg.sv
// Package: shared constants for the PWM timer.
// Holds the register offsets that software decodes and the counter source codes.
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_FIX = 2'd2,
        SRC_EXT = 2'd3
    } src_e;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h04;
    localparam logic [7:0] OFS_END    = 8'h08;
    localparam logic [7:0] OFS_CHMODE = 8'h0C;
    localparam logic [7:0] OFS_CHCMP  = 8'h10;
    localparam int         CH_STRIDE  = 8;
    localparam logic [7:0] OFS_START  = 8'h4C;
    localparam logic [7:0] OFS_IDLE   = 8'h5C;
    localparam logic [7:0] OFS_MASK   = 8'h60;
    localparam logic [7:0] OFS_INV    = 8'h70;

endpackage

// File: rtl/pwm_tick_gen.sv
// Module: pwm_tick_gen
// Picks the counter tick source and divides it by 2^ps.
// Assumes: fix_tick is already in the clk domain. ext_clk is asynchronous,
// and its high and low phases each last at least two clk periods.
module pwm_tick_gen
    import pwm_timer_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  src_e            src_sel,
    input  logic [PS_W-1:0] ps,
    input  logic            fix_tick,
    input  logic            ext_clk,
    output logic            cnt_tick
);
    localparam int PRE_W = (1 << PS_W) - 1;

    logic [2:0]       ext_sync;
    logic             ext_rise;
    logic             src_tick;
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_limit;

    // Synchronise the external clock and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync <= '0;
        else        ext_sync <= {ext_sync[1:0], ext_clk};
    end

    assign ext_rise = ext_sync[1] & ~ext_sync[2];

    // Select the raw tick from the programmed source.
    always_comb begin
        case (src_sel)
            SRC_SYS: src_tick = 1'b1;
            SRC_FIX: src_tick = fix_tick;
            SRC_EXT: src_tick = ext_rise;
            default: src_tick = 1'b0;
        endcase
    end

    assign pre_limit = PRE_W'((32'd1 << ps) - 32'd1);

    // Prescaler: count raw ticks and release one in every 2^ps.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pre_cnt <= '0;
        else if (src_tick) begin
            if (pre_cnt >= pre_limit)     pre_cnt <= '0;
            else                          pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign cnt_tick = src_tick && (pre_cnt >= pre_limit);
endmodule

// File: rtl/pwm_count_core.sv
// Module: pwm_count_core
// Shared up-counter with double-buffered end and compare values.
// Assumes: shadow values come from the register file. They load at a wrap,
// or on every cycle while the counter is stopped.
module pwm_count_core #(
    parameter int CNT_W = 16,
    parameter int NCH   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      stopped,
    input  logic [CNT_W-1:0]          start_val,
    input  logic [CNT_W-1:0]          end_sh,
    input  logic [NCH-1:0][CNT_W-1:0] cmp_sh,
    output logic [CNT_W-1:0]          cnt,
    output logic [CNT_W-1:0]          end_act,
    output logic [NCH-1:0][CNT_W-1:0] cmp_act,
    output logic                      wrap
);
    assign wrap = tick && (cnt >= end_act);

    // Advance the counter, or reload the start value at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= wrap ? start_val : cnt + 1'b1;
    end

    // Move the shadow values into the active set at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_act <= '0;
            cmp_act <= '0;
        end else if (wrap || stopped) begin
            end_act <= end_sh;
            cmp_act <= cmp_sh;
        end
    end
endmodule

// File: rtl/pwm_chan_out.sv
// Module: pwm_chan_out
// One output stage: compare, mask to the idle level, invert, then register.
// Assumes: cmp is the active (buffered) compare value.
module pwm_chan_out #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             pwm_mode,
    input  logic             masked,
    input  logic             idle_lvl,
    input  logic             invert,
    output logic             pwm
);
    logic level;

    // Pick the idle level when masked, otherwise the compare result.
    assign level = masked ? idle_lvl : (pwm_mode && (cnt < cmp));

    // Register the output so it never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm <= 1'b0;
        else        pwm <= level ^ invert;
    end
endmodule

// File: rtl/shared_pwm_timer.sv
// Module: shared_pwm_timer (top)
// Eight-channel edge-aligned PWM timer with a single shared counter.
// Holds the register file and wires the tick generator, the counter core
// and the per-channel output stages together.
// Assumes: a single-cycle write strobe, and read data taken combinationally.
module shared_pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NCH    = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fix_tick,
    input  logic              ext_clk,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    localparam int PS_W      = 3;
    localparam int MODE_W    = 8;
    localparam int BIT_PWM_A = 5;
    localparam int BIT_PWM_B = 3;

    logic [DATA_W-1:0]            ctrl_q;
    logic [CNT_W-1:0]             end_q;
    logic [CNT_W-1:0]             start_q;
    logic [NCH-1:0][CNT_W-1:0]    cmp_q;
    logic [NCH-1:0][MODE_W-1:0]   mode_q;
    logic [NCH-1:0]               idle_q;
    logic [NCH-1:0]               mask_q;
    logic [NCH-1:0]               inv_q;

    logic                         cnt_tick;
    logic                         cnt_wrap;
    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             end_act;
    logic [NCH-1:0][CNT_W-1:0]    cmp_act;
    src_e                         src_sel;

    assign src_sel = src_e'(ctrl_q[4:3]);

    // Register writes; the counter address is read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            end_q   <= '0;
            start_q <= '0;
            cmp_q   <= '0;
            mode_q  <= '0;
            idle_q  <= '0;
            mask_q  <= '1;
            inv_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL:  ctrl_q  <= bus_wdata;
                OFS_END:   end_q   <= bus_wdata[CNT_W-1:0];
                OFS_START: start_q <= bus_wdata[CNT_W-1:0];
                OFS_IDLE:  idle_q  <= bus_wdata[NCH-1:0];
                OFS_MASK:  mask_q  <= bus_wdata[NCH-1:0];
                OFS_INV:   inv_q   <= bus_wdata[NCH-1:0];
                default: ;
            endcase
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == ADDR_W'(OFS_CHMODE + CH_STRIDE * i))
                    mode_q[i] <= bus_wdata[MODE_W-1:0];
                if (bus_addr == ADDR_W'(OFS_CHCMP + CH_STRIDE * i))
                    cmp_q[i] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // Read path: the live count, or the stored value of the other registers.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:  bus_rdata = ctrl_q;
            OFS_COUNT: bus_rdata = DATA_W'(cnt_q);
            OFS_END:   bus_rdata = DATA_W'(end_q);
            OFS_START: bus_rdata = DATA_W'(start_q);
            OFS_IDLE:  bus_rdata = DATA_W'(idle_q);
            OFS_MASK:  bus_rdata = DATA_W'(mask_q);
            OFS_INV:   bus_rdata = DATA_W'(inv_q);
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(OFS_CHMODE + CH_STRIDE * i))
                bus_rdata = DATA_W'(mode_q[i]);
            if (bus_addr == ADDR_W'(OFS_CHCMP + CH_STRIDE * i))
                bus_rdata = DATA_W'(cmp_q[i]);
        end
    end

    pwm_tick_gen #(.PS_W(PS_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .ps       (ctrl_q[PS_W-1:0]),
        .fix_tick (fix_tick),
        .ext_clk  (ext_clk),
        .cnt_tick (cnt_tick)
    );

    pwm_count_core #(.CNT_W(CNT_W), .NCH(NCH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .stopped   (src_sel == SRC_OFF),
        .start_val (start_q),
        .end_sh    (end_q),
        .cmp_sh    (cmp_q),
        .cnt       (cnt_q),
        .end_act   (end_act),
        .cmp_act   (cmp_act),
        .wrap      (cnt_wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_chan_out #(.CNT_W(CNT_W)) u_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt_q),
            .cmp      (cmp_act[g]),
            .pwm_mode (mode_q[g][BIT_PWM_A] & mode_q[g][BIT_PWM_B]),
            .masked   (mask_q[g]),
            .idle_lvl (idle_q[g]),
            .invert   (inv_q[g]),
            .pwm      (pwm_out[g])
        );
    end
endmodule

// Checker: temporal properties of the shared counter, the buffers and the masked outputs.
module shared_pwm_timer_chk #(
    parameter int CNT_W = 16,
    parameter int NCH   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       src_sel,
    input logic             tick,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] start_val,
    input logic [CNT_W-1:0] end_act,
    input logic [NCH-1:0]   mask,
    input logic [NCH-1:0]   idle,
    input logic [NCH-1:0]   inv,
    input logic [NCH-1:0]   pwm_out
);
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd0) |=> $stable(cnt)); // R2
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == $past(start_val))); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (cnt == $past(cnt) + 1'b1)); // R4
    AST_END_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && src_sel != 2'd0) |=> $stable(end_act)); // R7
    for (genvar n = 0; n < NCH; n++) begin : g_mask
        AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            mask[n] |=> (pwm_out[n] == ($past(idle[n]) ^ $past(inv[n])))); // R8
    end
endmodule

bind shared_pwm_timer shared_pwm_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (ctrl_q[4:3]),
    .tick      (cnt_tick),
    .wrap      (cnt_wrap),
    .cnt       (cnt_q),
    .start_val (start_q),
    .end_act   (end_act),
    .mask      (mask_q),
    .idle      (idle_q),
    .inv       (inv_q),
    .pwm_out   (pwm_out)
);

// File: tb/tb_shared_pwm_timer.sv
// Directed bench for shared_pwm_timer: one task per scenario.
module tb_shared_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fix_tick = 1'b0;
    logic        ext_clk = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pwm_out;
    int          checks = 0;
    int          errors = 0;

    localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_END = 8'h08,
                           A_START = 8'h4C, A_IDLE = 8'h5C, A_MASK = 8'h60, A_INV = 8'h70;

    shared_pwm_timer dut (.*);

    always #2 clk = ~clk;

    // Fixed-rate tick: one pulse in every 3 cycles.
    initial forever begin
        repeat (2) @(negedge clk) fix_tick = 1'b0;
        @(negedge clk) fix_tick = 1'b1;
    end

    // External clock: 8 system cycles per period.
    initial forever begin
        repeat (4) @(negedge clk);
        ext_clk = ~ext_clk;
    end

    function automatic logic [7:0] a_mode(input int ch); return 8'(8'h0C + 8 * ch); endfunction
    function automatic logic [7:0] a_cmp(input int ch);  return 8'(8'h10 + 8 * ch); endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic high_count(input int ch, input int cycles, output int n);
        n = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            n += int'(pwm_out[ch]);
        end
    endtask

    task automatic run(input int src, input int ps, input int endv, input int startv, input int settle);
        wr(A_CTRL, 0);
        wr(A_END, endv);
        wr(A_START, startv);
        wr(A_CTRL, (src << 3) | ps);
        repeat (settle) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R8 outputs after reset", {24'b0, pwm_out}, 0);
        rd(A_MASK, d); chk("R8 mask after reset", d, 32'hFF);
        rd(A_CNT, d);  chk("R10 count after reset", d, 0);
    endtask

    task automatic t_readback();
        logic [31:0] d, v;
        wr(A_CTRL, 32'hA5A50007); rd(A_CTRL, d); chk("R1 control readback", d, 32'hA5A50007);
        wr(A_END, 32'h1234);      rd(A_END, d);  chk("R1 end readback", d, 32'h1234);
        wr(a_cmp(3), 32'h0BEE);   rd(a_cmp(3), d); chk("R1 compare readback", d, 32'h0BEE);
        wr(a_mode(5), 32'h28);    rd(a_mode(5), d); chk("R1 mode readback", d, 32'h28);
        wr(A_INV, 32'h81);        rd(A_INV, d);  chk("R1 invert readback", d, 32'h81);
        wr(A_INV, 0);
        rd(A_CNT, v);
        repeat (5) @(negedge clk);
        rd(A_CNT, d); chk("R2 stopped counter holds", d, v);
        wr(A_CNT, 32'h55);
        rd(A_CNT, d); chk("R10 count write ignored", d, v);
    endtask

    task automatic t_duty();
        logic [31:0] d0, d1;
        int n;
        wr(A_CTRL, 0);
        wr(a_mode(0), 32'h28); wr(a_cmp(0), 4);
        wr(a_mode(1), 32'h28); wr(a_cmp(1), 7);
        wr(a_mode(2), 32'h00); wr(a_cmp(2), 5);
        wr(a_mode(3), 32'h28); wr(a_cmp(3), 0);
        wr(a_mode(4), 32'h28); wr(a_cmp(4), 12);
        wr(A_MASK, 32'hE0);
        run(1, 0, 9, 0, 30);
        high_count(0, 10, n); chk("R5 duty cmp 4 of 10", n, 4);
        high_count(1, 10, n); chk("R4 duty cmp 7 of 10", n, 7);
        high_count(2, 10, n); chk("R5 non-PWM mode inactive", n, 0);
        high_count(3, 10, n); chk("R6 cmp 0 inactive", n, 0);
        high_count(4, 10, n); chk("R6 cmp above end active", n, 10);
        rd(A_CNT, d0); rd(A_CNT, d1);
        chk("R10 live count advances", d1, (d0 == 9) ? 0 : d0 + 1);
    endtask

    task automatic t_timing();
        logic [31:0] d;
        bit hit = 0;
        for (int k = 0; k < 40 && !hit; k++) begin
            rd(A_CNT, d);
            if (d == 4) hit = 1;
        end
        chk("R12 output lags counter (count 3)", pwm_out[0], 1);
        @(negedge clk);
        chk("R12 output lags counter (count 4)", pwm_out[0], 0);
    endtask

    task automatic t_buffer();
        logic [31:0] d;
        int n;
        bit hit = 0;
        wr(a_cmp(0), 5);
        repeat (30) @(negedge clk);
        for (int k = 0; k < 40 && !hit; k++) begin
            rd(A_CNT, d);
            if (d == 2) hit = 1;
        end
        bus_addr = a_cmp(0); bus_wdata = 1; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        chk("R7 compare write held until wrap", pwm_out[0], 1);
        repeat (20) @(negedge clk);
        high_count(0, 10, n); chk("R7 new compare after wrap", n, 1);
        wr(a_cmp(0), 4);
    endtask

    task automatic t_prescale();
        int n;
        run(1, 2, 9, 0, 120);
        high_count(0, 40, n); chk("R3 prescale 4", n, 16);
        wr(a_cmp(0), 1);
        run(1, 7, 3, 0, 1100);
        high_count(0, 512, n); chk("R3 prescale 128", n, 128);
        wr(a_cmp(0), 4);
    endtask

    task automatic t_start();
        int n;
        wr(a_cmp(0), 7);
        run(1, 0, 9, 4, 30);
        high_count(0, 6, n); chk("R4 nonzero start value", n, 3);
        wr(a_cmp(0), 4);
    endtask

    task automatic t_sources();
        int n;
        run(2, 0, 9, 0, 90);
        high_count(0, 30, n); chk("R2 fixed-rate source", n, 12);
        run(3, 0, 9, 0, 240);
        high_count(0, 80, n); chk("R11 external clock source", n, 32);
    endtask

    task automatic t_mask_inv();
        int n;
        run(1, 0, 9, 0, 30);
        wr(A_INV, 32'h01);
        high_count(0, 10, n); chk("R9 invert PWM level", n, 6);
        wr(A_INV, 0); wr(A_IDLE, 32'h01); wr(A_MASK, 32'hFF);
        high_count(0, 10, n); chk("R8 masked drives idle 1", n, 10);
        wr(A_INV, 32'h01);
        high_count(0, 10, n); chk("R9 invert masked idle", n, 0);
        wr(A_INV, 0); wr(A_IDLE, 0);
        high_count(0, 10, n); chk("R8 masked drives idle 0", n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_duty();
        t_timing();
        t_buffer();
        t_prescale();
        t_start();
        t_sources();
        t_mask_inv();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule